// File: doc/BRIEF.md
# Burst-Mode DMA Channel Sequencer

This block is one DMA channel that copies a run of bytes or 16-bit words from one external memory area to another in burst mode. Once a request finds the channel enabled, the channel takes the external bus. Each transfer unit is one read access followed at once by one write access. Units run back to back until the transfer counter reaches zero. While the channel owns the bus, requests from every other channel stay pending, whatever their priority.

A non-maskable interrupt clears the channel enable. If a burst is already running, the unit in flight (its read and its write) still completes. The bus is then released and the rest of the count is dropped. A unit that is the final one of the burst therefore always completes. An optional end-of-transfer output marks the final unit. Each access takes two clock states. The source and destination counters advance by the unit size, and the count drops by one after every write.

Top module: `dma_burst_seq`

## Requirements
- R1: A pulse on cfg_load while the bus is not owned stores source, destination, count, size (cfg_word=1 word, 0 byte) and the end-of-transfer enable. chan_en is 1 after the next edge if the count is nonzero and nmi is low, and 0 otherwise. cfg_load is ignored while bus_own is high.
- R2: A read access lasts exactly two cycles with bus_rd high and bus_addr equal to the source counter. In byte mode the byte is taken from bus_rdata[15:8] at an even source address and from bus_rdata[7:0] at an odd one.
- R3: A write access of exactly two cycles follows each read immediately, with bus_addr equal to the destination counter. A word write raises both strobes. A byte write raises bus_wr_hi at an even destination address and bus_wr_lo at an odd one, with the byte on both halves of bus_wdata.
- R4: With chan_en=1 and dreq=1 (nmi low) while idle, bus_own rises after the next edge. Units then follow each other with no gap. other_grant equals other_req only while bus_own is low.
- R5: After each unit both address counters grow by 2 (word) or 1 (byte) and the count drops by 1. When the count reaches zero the bus is released and chan_en clears.
- R6: nmi clears chan_en at the next edge. A channel cleared this way starts no burst even when dreq is high.
- R7: An nmi during a burst lets the current unit finish both its accesses, then releases the bus. The remaining units are abandoned and nothing restarts until a new cfg_load.
- R8: With end-of-transfer enabled, tend_out is high for all four cycles of the final unit. It is low at all other times, and always low when disabled.
- R9: An nmi that arrives during the final unit does not cut it short: its write completes and tend_out stays asserted through it.
- R10: During and after reset the bus is not owned, all strobes are low and chan_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load channel settings and set enable |
| cfg_src | input | ADDR_W | Start source address |
| cfg_dst | input | ADDR_W | Start destination address |
| cfg_count | input | CNT_W | Number of units |
| cfg_word | input | 1 | 1 = word units, 0 = byte units |
| cfg_tend_en | input | 1 | Enable end-of-transfer output |
| dreq | input | 1 | Channel transfer request |
| nmi | input | 1 | Non-maskable interrupt |
| other_req | input | 1 | Bus request from the other channels |
| other_grant | output | 1 | Grant to the other channels |
| chan_en | output | 1 | Channel enable state |
| bus_own | output | 1 | Channel holds the external bus |
| bus_addr | output | ADDR_W | External address |
| bus_rd | output | 1 | Read strobe |
| bus_wr_hi | output | 1 | Upper byte write strobe |
| bus_wr_lo | output | 1 | Lower byte write strobe |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data |
| tend_out | output | 1 | End-of-transfer marker |

## Verification
The bench runs word bursts at even addresses and byte bursts that start at odd addresses. These separate the lane choice on read and the strobe choice on write, which a word-only run could not tell apart. Holding other_req high through a burst shows that the other channels stay locked out until release. An nmi that lands mid-burst, in the final unit, and while enabled but idle separates three cases: dropping the remaining units, completing the final unit anyway, and blocking a start. A zero-count load and a load issued mid-burst show when the settings are refused.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RD1  = 3'd1,
    PH_RD2  = 3'd2,
    PH_WR1  = 3'd3,
    PH_WR2  = 3'd4
  } phase_e;

  // address increment per unit
  function automatic logic [2:0] unit_step(input logic word);
    return word ? 3'd2 : 3'd1;
  endfunction

  // write strobes {hi, lo} from size and destination lsb
  function automatic logic [1:0] write_lanes(input logic word, input logic addr_lsb);
    if (word) return 2'b11;
    return addr_lsb ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_burst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cfg_load,
  input  logic   cfg_count_nz,
  input  logic   dreq,
  input  logic   nmi,
  input  logic   cnt_last,
  output phase_e phase,
  output logic   en,
  output logic   start_evt,
  output logic   unit_done,
  output logic   abort_evt
);

  phase_e ph_q, ph_d;
  logic   en_q;
  logic   idle;

  assign idle      = (ph_q == PH_IDLE);
  assign start_evt = idle && en_q && dreq && !nmi;
  assign unit_done = (ph_q == PH_WR2);
  assign abort_evt = nmi && en_q;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (start_evt) ph_d = PH_RD1;
      PH_RD1:  ph_d = PH_RD2;
      PH_RD2:  ph_d = PH_WR1;
      PH_WR1:  ph_d = PH_WR2;
      PH_WR2:  ph_d = (cnt_last || !en_q || nmi) ? PH_IDLE : PH_RD1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      en_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (nmi)
        en_q <= 1'b0;
      else if (cfg_load && idle)
        en_q <= cfg_count_nz;
      else if (unit_done && cnt_last)
        en_q <= 1'b0;
    end
  end

  assign phase = ph_q;
  assign en    = en_q;

endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_burst_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              ld_word,
  input  logic              ld_tend,
  input  logic              step,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [CNT_W-1:0]  cnt,
  output logic              word,
  output logic              tend_en,
  output logic              last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [ADDR_W-1:0] inc;

  assign inc = ADDR_W'(unit_step(word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src     <= '0;
      dst     <= '0;
      cnt     <= '0;
      word    <= 1'b0;
      tend_en <= 1'b0;
    end else if (load) begin
      src     <= ld_src;
      dst     <= ld_dst;
      cnt     <= ld_cnt;
      word    <= ld_word;
      tend_en <= ld_tend;
    end else if (step) begin
      src <= src + inc;
      dst <= dst + inc;
      cnt <= cnt - ONE;
    end
  end

  assign last = (cnt == ONE);

endmodule

// File: rtl/dma_bus_drv.sv
module dma_bus_drv
  import dma_burst_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic              word,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr_hi,
  output logic              bus_wr_lo,
  output logic [DATA_W-1:0] bus_wdata
);

  localparam int HALF = DATA_W / 2;

  logic              rd_ph, wr_ph;
  logic [1:0]        lanes;
  logic [HALF-1:0]   byte_v;
  logic [DATA_W-1:0] data_q;

  assign rd_ph  = (phase == PH_RD1) || (phase == PH_RD2);
  assign wr_ph  = (phase == PH_WR1) || (phase == PH_WR2);
  assign byte_v = src[0] ? bus_rdata[HALF-1:0] : bus_rdata[DATA_W-1:HALF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (phase == PH_RD2)
      data_q <= word ? bus_rdata : {{HALF{1'b0}}, byte_v};
  end

  assign lanes     = write_lanes(word, dst[0]);
  assign bus_rd    = rd_ph;
  assign bus_wr_hi = wr_ph && lanes[1];
  assign bus_wr_lo = wr_ph && lanes[0];
  assign bus_addr  = rd_ph ? src : (wr_ph ? dst : '0);
  assign bus_wdata = !wr_ph ? '0 :
                     (word ? data_q : {data_q[HALF-1:0], data_q[HALF-1:0]});

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_burst_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_word,
  input  logic              cfg_tend_en,
  input  logic              dreq,
  input  logic              nmi,
  input  logic              other_req,
  output logic              other_grant,
  output logic              chan_en,
  output logic              bus_own,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr_hi,
  output logic              bus_wr_lo,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              tend_out
);

  phase_e            phase;
  logic              start_evt, unit_done, abort_evt;
  logic              load_ok, cnt_last, word_q, tend_en_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;

  assign load_ok = cfg_load && (phase == PH_IDLE);

  dma_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .cfg_count_nz (cfg_count != '0),
    .dreq         (dreq),
    .nmi          (nmi),
    .cnt_last     (cnt_last),
    .phase        (phase),
    .en           (chan_en),
    .start_evt    (start_evt),
    .unit_done    (unit_done),
    .abort_evt    (abort_evt)
  );

  dma_addr_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_ok),
    .ld_src  (cfg_src),
    .ld_dst  (cfg_dst),
    .ld_cnt  (cfg_count),
    .ld_word (cfg_word),
    .ld_tend (cfg_tend_en),
    .step    (unit_done),
    .src     (src_q),
    .dst     (dst_q),
    .cnt     (cnt_q),
    .word    (word_q),
    .tend_en (tend_en_q),
    .last    (cnt_last)
  );

  dma_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .src       (src_q),
    .dst       (dst_q),
    .word      (word_q),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr_hi (bus_wr_hi),
    .bus_wr_lo (bus_wr_lo),
    .bus_wdata (bus_wdata)
  );

  assign bus_own     = (phase != PH_IDLE);
  assign other_grant = other_req && !bus_own;
  assign tend_out    = tend_en_q && bus_own && cnt_last;

endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             bus_own,
  input logic             bus_rd,
  input logic             bus_wr_hi,
  input logic             bus_wr_lo,
  input logic             tend_out,
  input logic             start_evt,
  input logic             unit_done,
  input logic             abort_evt,
  input logic [CNT_W-1:0] cnt
);

  logic wr_any;
  assign wr_any = bus_wr_hi || bus_wr_lo;

  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && wr_any));

  assert_read_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |=> bus_rd);

  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd) |-> wr_any);

  assert_write_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_any) |=> wr_any);

  assert_start_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (bus_own && bus_rd));

  assert_hold_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_own && !unit_done) |=> bus_own);

  assert_cnt_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_abort_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !chan_en);

  assert_no_start_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !bus_own) |=> !bus_own);

  assert_tend_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tend_out |-> bus_own);

endmodule

bind dma_burst_seq dma_burst_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .bus_own   (bus_own),
  .bus_rd    (bus_rd),
  .bus_wr_hi (bus_wr_hi),
  .bus_wr_lo (bus_wr_lo),
  .tend_out  (tend_out),
  .start_evt (start_evt),
  .unit_done (unit_done),
  .abort_evt (abort_evt),
  .cnt       (cnt_q)
);

// File: tb/dma_burst_seq_bench.sv
module dma_burst_seq_bench;

  localparam int AW = 24;
  localparam int CW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_src = '0;
  logic [AW-1:0] cfg_dst = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          cfg_word = 1'b0;
  logic          cfg_tend_en = 1'b0;
  logic          dreq = 1'b0;
  logic          nmi = 1'b0;
  logic          other_req = 1'b0;
  logic          other_grant, chan_en, bus_own, bus_rd, bus_wr_hi, bus_wr_lo, tend_out;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5AC3;
  endfunction

  assign bus_rdata = mem_val(bus_addr);

  dma_burst_seq u_dma_burst_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_word(cfg_word), .cfg_tend_en(cfg_tend_en), .dreq(dreq),
    .nmi(nmi), .other_req(other_req), .other_grant(other_grant), .chan_en(chan_en),
    .bus_own(bus_own), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr_hi(bus_wr_hi),
    .bus_wr_lo(bus_wr_lo), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tend_out(tend_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_units = 0;
  bit tend_seen = 1'b0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1..2 read, 3..4 write
  int            m_ph;
  bit            m_en, m_word, m_tend;
  logic [AW-1:0] m_src, m_dst;
  int            m_cnt;
  logic [15:0]   m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_en <= 0; m_word <= 0; m_tend <= 0;
      m_src <= '0; m_dst <= '0; m_cnt <= 0; m_data <= '0;
    end else begin
      if (m_ph == 0) begin
        if (m_en && dreq && !nmi) m_ph <= 1;
        if (cfg_load) begin
          m_src <= cfg_src; m_dst <= cfg_dst; m_cnt <= int'(cfg_count);
          m_word <= cfg_word; m_tend <= cfg_tend_en;
        end
      end else if (m_ph == 2) begin
        m_ph <= 3;
        if (m_word) m_data <= mem_val(m_src);
        else m_data <= {8'h00, (m_src[0] ? mem_val(m_src) : (mem_val(m_src) >> 8)) & 16'h00FF} & 16'h00FF;
      end else if (m_ph == 4) begin
        m_src <= m_src + (m_word ? 2 : 1);
        m_dst <= m_dst + (m_word ? 2 : 1);
        m_cnt <= m_cnt - 1;
        m_ph <= (m_cnt == 1 || !m_en || nmi) ? 0 : 1;
      end else begin
        m_ph <= m_ph + 1;
      end
      if (nmi) m_en <= 0;
      else if (cfg_load && m_ph == 0) m_en <= (cfg_count != 0);
      else if (m_ph == 4 && m_cnt == 1) m_en <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      bit rd_e, wr_e;
      rd_e = (m_ph == 1 || m_ph == 2);
      wr_e = (m_ph == 3 || m_ph == 4);
      chk("R2", "bus_rd", 32'(bus_rd), 32'(rd_e));
      chk("R3", "bus_wr_hi", 32'(bus_wr_hi), 32'(wr_e && (m_word || !m_dst[0])));
      chk("R3", "bus_wr_lo", 32'(bus_wr_lo), 32'(wr_e && (m_word || m_dst[0])));
      chk("R5", "bus_addr", 32'(bus_addr), 32'(rd_e ? m_src : (wr_e ? m_dst : '0)));
      chk("R3", "bus_wdata", 32'(bus_wdata),
          32'(!wr_e ? 16'h0 : (m_word ? m_data : {m_data[7:0], m_data[7:0]})));
      chk("R4", "bus_own", 32'(bus_own), 32'(m_ph != 0));
      chk("R4", "other_grant", 32'(other_grant), 32'(other_req && m_ph == 0));
      chk("R8", "tend_out", 32'(tend_out), 32'(m_tend && m_ph != 0 && m_cnt == 1));
      chk("R6", "chan_en", 32'(chan_en), 32'(m_en));
      if (bus_wr_hi || bus_wr_lo) begin
        if (u_wr_prev == 1'b0) n_units++;
      end
      if (tend_out) tend_seen = 1'b1;
    end
  end

  bit u_wr_prev = 1'b0;
  always @(posedge clk) u_wr_prev <= bus_wr_hi || bus_wr_lo;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d, input int c,
                      input bit w, input bit t);
    cfg_src = s; cfg_dst = d; cfg_count = CW'(c); cfg_word = w; cfg_tend_en = t;
    cfg_load = 1'b1;
    step(1);
    cfg_load = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(2);
    // R10 reset state
    chk("R10", "reset bus_own", 32'(bus_own), 32'd0);
    chk("R10", "reset strobes", 32'({bus_rd, bus_wr_hi, bus_wr_lo}), 32'd0);
    chk("R10", "reset chan_en", 32'(chan_en), 32'd0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    step(2);

    // word burst with other channels waiting; R1 load, R4, R5, R8
    other_req = 1'b1;
    load(24'h000100, 24'h000200, 3, 1'b1, 1'b1);
    chk("R1", "enable after load", 32'(chan_en), 32'd1);
    dreq = 1'b1;
    n_units = 0; tend_seen = 1'b0;
    step(5);
    load(24'h00AAAA, 24'h00BBBB, 9, 1'b0, 1'b0); // ignored mid-burst, R1
    step(20);
    chk("R5", "word units done", 32'(n_units), 32'd3);
    chk("R8", "tend seen", 32'(tend_seen), 32'd1);
    chk("R5", "enable cleared at end", 32'(chan_en), 32'd0);
    chk("R4", "grant after release", 32'(other_grant), 32'd1);
    dreq = 1'b0; other_req = 1'b0;

    // byte burst at odd source, even destination, no tend; R2, R3, R8
    load(24'h000301, 24'h000400, 4, 1'b0, 1'b0);
    dreq = 1'b1; n_units = 0; tend_seen = 1'b0;
    step(22);
    chk("R3", "byte units done", 32'(n_units), 32'd4);
    chk("R8", "tend stays low", 32'(tend_seen), 32'd0);
    dreq = 1'b0;

    // zero count refused; R1
    load(24'h000010, 24'h000020, 0, 1'b1, 1'b0);
    chk("R1", "zero count enable", 32'(chan_en), 32'd0);
    dreq = 1'b1; step(4);
    chk("R1", "zero count no burst", 32'(bus_own), 32'd0);
    dreq = 1'b0;

    // nmi mid burst; R7
    load(24'h000500, 24'h000601, 5, 1'b0, 1'b1);
    dreq = 1'b1; n_units = 0; tend_seen = 1'b0;
    step(6);
    nmi = 1'b1; step(1); nmi = 1'b0;
    step(12);
    chk("R7", "units before abort", 32'(n_units), 32'd2);
    chk("R7", "bus released", 32'(bus_own), 32'd0);
    chk("R7", "enable cleared", 32'(chan_en), 32'd0);
    chk("R7", "tend never reached", 32'(tend_seen), 32'd0);
    dreq = 1'b0;

    // nmi in the final unit; R9
    load(24'h000700, 24'h000800, 1, 1'b1, 1'b1);
    dreq = 1'b1; n_units = 0; tend_seen = 1'b0;
    step(3);
    nmi = 1'b1; step(1); nmi = 1'b0;
    step(8);
    chk("R9", "final unit written", 32'(n_units), 32'd1);
    chk("R9", "final tend", 32'(tend_seen), 32'd1);
    dreq = 1'b0;

    // nmi while enabled but idle; R6
    load(24'h000900, 24'h000A00, 2, 1'b1, 1'b0);
    nmi = 1'b1; step(1); nmi = 1'b0;
    dreq = 1'b1; step(6);
    chk("R6", "no start after nmi", 32'(bus_own), 32'd0);
    dreq = 1'b0;

    // re-enable works again; R7
    load(24'h000B00, 24'h000C00, 2, 1'b1, 1'b0);
    dreq = 1'b1; n_units = 0;
    step(12);
    chk("R7", "restart after reload", 32'(n_units), 32'd2);
    dreq = 1'b0;
    step(3);
    finish_run();
  end

endmodule